// File: doc/BRIEF.md
# Across-Lanes Minimum/Maximum Reduction Unit

This unit reduces every lane of a 128-bit source vector to a single minimum or maximum. It takes a 32-bit instruction word, decodes the comparison kind, the lane width and the operand width from it, and places the winning lane in the least significant lane of a 128-bit result. Every other result bit is cleared.

Lanes are 8, 16 or 32 bits wide, and the comparison is either signed or unsigned. For a half-width operation the lower 64 bits of the source are copied over the upper 64 bits, so that one full-width pairwise tree serves both widths. Instruction words that do not fit the recognised pattern, or that ask for a lane width the operation does not allow, raise an illegal flag and produce a zero result.

The result is registered. It appears one cycle after an input strobe, together with a valid pulse.

Top module: `lane_minmax_reduce`

## Requirements
- R1: An instruction word is accepted only when bit 31 = 0, bits 28:24 = 01110, bits 21:17 = 11000 and bits 15:10 = 101010. Any other word sets `out_illegal`. Bits 9:0 are ignored.
- R2: Bits 23:22 hold the lane-size code: 0 selects 8-bit lanes, 1 selects 16-bit lanes and 2 selects 32-bit lanes. Code 3 sets `out_illegal`.
- R3: Size code 2 together with bit 30 = 0 (half width) sets `out_illegal`.
- R4: When `out_illegal` is set, `result_vec` is all zeros.
- R5: Bit 29 = 1 compares lanes as unsigned magnitudes. Bit 29 = 0 compares them as two's-complement values.
- R6: Bit 16 = 1 selects the minimum and bit 16 = 0 selects the maximum.
- R7: When bit 30 = 0, only `src_vec[63:0]` takes part in the reduction, and the upper half of the source has no effect on the result.
- R8: A legal result sits in the low lane. Bits above the lane width are zero: 120 bits for 8-bit lanes, 112 bits for 16-bit lanes and 96 bits for 32-bit lanes.
- R9: `out_valid` is high exactly one cycle after each cycle in which `in_valid` is high. When no strobe arrives, `result_vec` and `out_illegal` hold their values.
- R10: After reset, `out_valid`, `out_illegal` and `result_vec` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: the instruction word and the source are valid this cycle |
| insn_word | input | 32 | Instruction word holding the operation fields |
| src_vec | input | 128 | Source vector operand |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_illegal | output | 1 | The accepted word is not a legal encoding |
| result_vec | output | 128 | Reduced lane in the low bits, zero elsewhere |

## Verification
A wrong tree node or a wrong comparison polarity shows up only when the extreme lane passes through that node. The bench therefore places the extreme value in low, middle and high lanes, and uses values whose sign bits flip the signed and unsigned orderings. Every such fault appears on `result_vec` in the cycle after the strobe.

A decode fault shows up one cycle after the strobe, either as a wrong `out_illegal` or as non-zero upper result bits. A duplication fault in half-width mode shows up only when the two source halves differ, so every half-width vector carries a decoy in the upper half.

// File: rtl/lane_minmax_reduce.sv
module lane_minmax_reduce #(
  parameter int VEC_W  = 128,
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn_word,
  input  logic [VEC_W-1:0]  src_vec,
  output logic              out_valid,
  output logic              out_illegal,
  output logic [VEC_W-1:0]  result_vec
);
  localparam int HALF_W = VEC_W / 2;
  localparam int NSZ    = 3;

  // field decode
  wire       pat_ok = (insn_word[31] == 1'b0) && (insn_word[28:24] == 5'b01110) &&
                      (insn_word[21:17] == 5'b11000) && (insn_word[15:10] == 6'b101010);
  wire       full_w = insn_word[30];
  wire       is_uns = insn_word[29];
  wire [1:0] sz     = insn_word[23:22];
  wire       is_min = insn_word[16];
  wire       bad    = !pat_ok || (sz == 2'd3) || (sz == 2'd2 && !full_w);

  wire [VEC_W-1:0] work = full_w ? src_vec : {2{src_vec[HALF_W-1:0]}};

  logic [VEC_W-1:0] red [4];
  assign red[3] = '0;

  for (genvar s = 0; s < NSZ; s++) begin : g_sz
    localparam int LW = 8 << s;
    localparam int NL = VEC_W / LW;
    localparam int LV = $clog2(NL);
    for (genvar l = 0; l <= LV; l++) begin : g_lv
      localparam int CNT = NL >> l;
      logic [CNT*LW-1:0] v;
      if (l == 0) begin : g_in
        assign v = work;
      end else begin : g_mix
        for (genvar j = 0; j < CNT; j++) begin : g_pair
          wire [LW-1:0] a = g_lv[l-1].v[(2*j)*LW +: LW];
          wire [LW-1:0] b = g_lv[l-1].v[(2*j+1)*LW +: LW];
          wire a_lt = {a[LW-1] ^ ~is_uns, a[LW-2:0]} < {b[LW-1] ^ ~is_uns, b[LW-2:0]};
          assign v[j*LW +: LW] = (is_min == a_lt) ? a : b;
        end
      end
    end
    assign red[s] = {{(VEC_W-LW){1'b0}}, g_lv[LV].v};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      result_vec  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_illegal <= bad;
        result_vec  <= bad ? '0 : red[sz];
      end
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result_vec) && $stable(out_illegal)));
  a_r2_size3_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn_word[23:22] == 2'd3) |=> out_illegal);
  a_r3_half32_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn_word[23:22] == 2'd2 && !insn_word[30]) |=> out_illegal);
  a_r4_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (result_vec == '0));
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn_word[23:22] == 2'd1) |=> (result_vec[VEC_W-1:16] == '0));
endmodule

// File: tb/lane_minmax_reduce_tb_top.sv
module lane_minmax_reduce_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  insn_word = '0;
  logic [127:0] src_vec = '0;
  logic         out_valid;
  logic         out_illegal;
  logic [127:0] result_vec;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_minmax_reduce dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn_word(insn_word),
    .src_vec(src_vec), .out_valid(out_valid), .out_illegal(out_illegal),
    .result_vec(result_vec)
  );

  function automatic logic [31:0] mk(input bit q, input bit u, input logic [1:0] sz, input bit mn);
    return {1'b0, q, u, 5'b01110, sz, 5'b11000, mn, 6'b101010, 10'h0};
  endfunction

  localparam logic [31:0] TV_OP [NV] = '{
    mk(1,0,2'd0,0), mk(1,1,2'd0,1), mk(0,0,2'd0,1), mk(1,1,2'd1,0),
    mk(0,0,2'd1,1), mk(1,0,2'd2,0), mk(1,1,2'd2,1), mk(0,1,2'd1,0)
  };
  localparam logic [127:0] TV_SRC [NV] = '{
    128'h80_7F_01_FE_33_C4_10_90_05_A0_7E_02_FF_00_81_40,
    128'h91_22_F3_44_05_66_77_18_99_AA_0B_CC_DD_EE_1F_30,
    128'h00_00_00_00_00_00_00_00_7F_85_22_81_10_F0_01_33,
    128'h1111_FFFE_8000_2222_0001_7FFF_ABCD_0042,
    128'h8000_8000_8000_8000_0044_FF00_1234_7000,
    128'h80000000_7FFFFFFF_FFFFFFFF_00000010,
    128'h00000003_80000000_00000002_FFFF0000,
    128'hFFFF_FFFF_FFFF_FFFF_0100_0200_E000_0003
  };

  function automatic void ref_model(input logic [31:0] op, input logic [127:0] src,
                                    output bit ill, output logic [127:0] res);
    bit q, u, mn;
    int lw;
    longint best, cur;
    logic [127:0] v;
    logic [1:0] sz;
    q = op[30]; u = op[29]; sz = op[23:22]; mn = op[16];
    ill = !(op[31] == 0 && op[28:24] == 5'b01110 && op[21:17] == 5'b11000 && op[15:10] == 6'b101010)
          || sz == 3 || (sz == 2 && !q);
    res = '0;
    if (ill) return;
    lw = 8 << sz;
    v = q ? src : {src[63:0], src[63:0]};
    best = 0;
    for (int i = 0; i < 128 / lw; i++) begin
      logic [127:0] raw;
      raw = (v >> (i * lw)) & ((128'd1 << lw) - 1);
      cur = longint'(raw[31:0]);
      if (!u && raw[lw-1]) cur = cur - (longint'(1) << lw);
      if (i == 0 || (mn ? (cur < best) : (cur > best))) best = cur;
    end
    res = 128'(best) & ((128'd1 << lw) - 1);
  endfunction

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] op, input logic [127:0] src);
    @(negedge clk);
    in_valid = 1'b1; insn_word = op; src_vec = src;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    bit ill;
    logic [127:0] exp;
    logic [127:0] held;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid", 128'(out_valid), 128'd0);
    check("R10 illegal", 128'(out_illegal), 128'd0);
    check("R10 data", result_vec, 128'd0);
    @(negedge clk); rst_n = 1'b1;

    // vector table: R5 R6 R7 R8
    for (int t = 0; t < NV; t++) begin
      ref_model(TV_OP[t], TV_SRC[t], ill, exp);
      apply(TV_OP[t], TV_SRC[t]);
      check("R9 valid pulse", 128'(out_valid), 128'd1);
      check("R8 table result", result_vec, exp);
      check("R1 table legal", 128'(out_illegal), 128'(ill));
    end

    // R5/R6 directed 16-bit cases
    apply(mk(1,0,2'd1,0), 128'h0000_1234_FFFF_8001_FFFF_0001_7FFF_8000);
    check("R5 signed max", result_vec, 128'h7FFF);
    apply(mk(1,1,2'd1,0), 128'h0000_1234_FFFF_8001_FFFF_0001_7FFF_8000);
    check("R5 unsigned max", result_vec, 128'hFFFF);
    apply(mk(1,0,2'd1,1), 128'h0000_1234_FFFF_8001_FFFF_0001_7FFF_8000);
    check("R6 signed min", result_vec, 128'h8000);
    apply(mk(1,1,2'd1,1), 128'h0000_1234_FFFF_8001_FFFF_0001_7FFF_8000);
    check("R6 unsigned min", result_vec, 128'h0000);
    apply(mk(1,0,2'd2,1), {32'h7000_0000, 32'hFFFF_FFFE, 32'h0000_0005, 32'h8000_0001});
    check("R5 signed min 32", result_vec, 128'h8000_0001);
    apply(mk(1,1,2'd2,1), {32'h7000_0000, 32'hFFFF_FFFE, 32'h0000_0005, 32'h8000_0001});
    check("R8 unsigned min 32", result_vec, 128'h5);

    // R7 half width ignores upper decoys
    apply(mk(0,1,2'd0,1), {64'h0, 64'h5555_5555_5510_5555});
    check("R7 half umin 8", result_vec, 128'h10);
    apply(mk(0,0,2'd1,0), {64'h7FFF_7FFF_7FFF_7FFF, 64'h0003_FFFF_0002_8000});
    check("R7 half smax 16", result_vec, 128'h0003);

    // R1 ignored low bits
    apply(mk(1,1,2'd0,0) | 32'h3FF, 128'h01_02_03_04_05_06_07_08_09_0A_0B_0C_0D_0E_C0_0F);
    check("R1 low bits ignored", result_vec, 128'hC0);
    check("R1 low bits legal", 128'(out_illegal), 128'd0);

    // R2 R3 R1 illegal encodings with R4 zero data
    apply(mk(1,0,2'd3,0), {128{1'b1}});
    check("R2 size3 illegal", 128'(out_illegal), 128'd1);
    check("R4 size3 zero", result_vec, 128'd0);
    apply(mk(0,0,2'd2,0), {128{1'b1}});
    check("R3 half 32 illegal", 128'(out_illegal), 128'd1);
    check("R4 half 32 zero", result_vec, 128'd0);
    apply(mk(1,0,2'd0,0) | 32'h8000_0000, {128{1'b1}});
    check("R1 bit31 illegal", 128'(out_illegal), 128'd1);
    apply(mk(1,0,2'd0,0) ^ 32'h0000_0400, {128{1'b1}});
    check("R1 opfield illegal", 128'(out_illegal), 128'd1);
    check("R4 opfield zero", result_vec, 128'd0);

    // R9 hold without strobe
    apply(mk(1,1,2'd0,0), 128'h42);
    held = result_vec;
    check("R9 result", held, 128'h42);
    @(negedge clk);
    insn_word = mk(1,0,2'd3,0); src_vec = {128{1'b1}};
    @(negedge clk);
    check("R9 no valid", 128'(out_valid), 128'd0);
    check("R9 data held", result_vec, held);
    check("R9 illegal held", 128'(out_illegal), 128'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule